// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block produces four independent pulse-width-modulated outputs from one input clock. The four channels are grouped in two pairs. Each pair shares an 8-bit prescaler, which divides the input clock by the stored value plus one. Each channel then applies its own power-of-two clock divider and runs a 16-bit down-counter. Two registers per channel set the waveform. The period register sets the number of counts per cycle. The compare register sets how many of those counts the output is high.

Software programs the block through a plain 32-bit register bus. Writes take effect on a clock edge when the write strobe is high. Reads are combinational from the address. A channel produces a waveform only when both its enable bit and its continuous-mode bit are set. Otherwise its pin stays low. An invert bit complements a running waveform. New period and compare values are held in shadow registers until the current cycle ends, so a reprogrammed channel never emits a truncated or stretched pulse.

Top module: `pwm_quad`

## Requirements
- R1: Register map (byte offsets):
  - 0x00 holds the two prescalers.
  - 0x04 holds the divider selects.
  - 0x08 holds the control fields.
  - Channel n has its period at 0x0C+8n and its compare at 0x10+8n, each in bits 15:0.
  - Every field reads back exactly as written. Bits outside the fields and unmapped offsets read as 0.
- R2: In the prescaler word, bits 7:0 divide the clock for channels 0 and 1, and bits 15:8 for channels 2 and 3. A value p divides the input clock by p+1.
- R3: Channel n has a 3-bit divider select at bit 4n of the select word. Codes 0, 1, 2 and 3 divide by 2, 4, 8 and 16. Code 4, and also codes 5 to 7, divide by 1.
- R4: A running channel with period N repeats every (p+1)·d·(N+1) input clocks, where d is the selected divider.
- R5: A running channel without inversion is high for (C+1)·(p+1)·d clocks of each cycle, where C is the compare value. When C ≥ N the output stays high for the whole cycle.
- R6: A running channel with period 0 outputs constant low, or constant high when inverted.
- R7: Each channel has a 4-bit control field in the control word, at bit 0, 8, 12 or 16 for channels 0 to 3. Field bit 0 is enable, bit 2 is invert and bit 3 is continuous mode. A channel runs only when enable and continuous are both set. Otherwise its output is low whatever the invert bit says.
- R8: During and after reset all outputs are low and every register reads 0.
- R9: A period or compare value written while a channel runs takes effect only at the next cycle boundary. The cycle in progress finishes with the old values.
- R10: With invert set, a running channel's output is the complement of its normal waveform. Its high time is the cycle length minus the normal high time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
A corrupted prescaler or divider count shifts every later edge. It shows at the port as a wrong cycle length within one cycle of the channel, so the bench measures the spacing of rising edges and the high time over exactly one expected cycle. A shadow register that loads at the wrong moment shows in the first pulse after a mid-cycle write, so the bench times that write just after a falling edge and measures the next two pulses. A stuck run decode or inversion flag shows on the output within one clock. The checker watches for it there and also tracks the counter against the held period.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
    localparam int NCH    = 4;
    localparam int NPAIR  = NCH / 2;
    localparam int PRE_W  = 8;
    localparam int SEL_W  = 3;
    localparam int CNT_W  = 16;
    localparam int DIV_W  = 4;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_PRESCALE = 6'h00;
    localparam logic [ADDR_W-1:0] A_DIVSEL   = 6'h04;
    localparam logic [ADDR_W-1:0] A_CONTROL  = 6'h08;

    // control field of one channel, bit 3 down to bit 0
    typedef struct packed {
        logic cont;
        logic inv;
        logic spare;
        logic en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [ADDR_W-1:0] period_addr(input int ch);
        return ADDR_W'(12 + 8 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] compare_addr(input int ch);
        return ADDR_W'(16 + 8 * ch);
    endfunction

    // control fields sit at 0, 8, 12, 16
    function automatic int ctl_lsb(input int ch);
        return (ch == 0) ? 0 : 4 + 4 * ch;
    endfunction

    function automatic int sel_lsb(input int ch);
        return 4 * ch;
    endfunction

    function automatic int pre_lsb(input int pair);
        return PRE_W * pair;
    endfunction

    // last value of the divider counter: ratio minus one
    function automatic logic [DIV_W-1:0] div_last(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    return DIV_W'(1);
            3'd1:    return DIV_W'(3);
            3'd2:    return DIV_W'(7);
            3'd3:    return DIV_W'(15);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
    import pwm_quad_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          we,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NPAIR-1:0][PRE_W-1:0]   pre_o,
    output logic [NCH-1:0][SEL_W-1:0]     sel_o,
    output logic [NCH-1:0]                en_o,
    output logic [NCH-1:0]                inv_o,
    output logic [NCH-1:0]                cont_o,
    output logic [NCH-1:0][CNT_W-1:0]     per_o,
    output logic [NCH-1:0][CNT_W-1:0]     cmp_o
);
    ctl_t [NCH-1:0] ctl_q;
    logic           unused_wbits;

    assign unused_wbits = ^wdata[DATA_W-1:20];

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_o <= '0;
            sel_o <= '0;
            ctl_q <= '0;
            per_o <= '0;
            cmp_o <= '0;
        end else if (we) begin
            if (addr == A_PRESCALE) begin
                for (int p = 0; p < NPAIR; p++) begin
                    pre_o[p] <= wdata[pre_lsb(p) +: PRE_W];
                end
            end
            if (addr == A_DIVSEL) begin
                for (int c = 0; c < NCH; c++) begin
                    sel_o[c] <= wdata[sel_lsb(c) +: SEL_W];
                end
            end
            if (addr == A_CONTROL) begin
                for (int c = 0; c < NCH; c++) begin
                    ctl_q[c] <= wdata[ctl_lsb(c) +: CTL_W];
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (addr == period_addr(c)) per_o[c] <= wdata[CNT_W-1:0];
                if (addr == compare_addr(c)) cmp_o[c] <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_PRESCALE) begin
            for (int p = 0; p < NPAIR; p++) rdata[pre_lsb(p) +: PRE_W] = pre_o[p];
        end
        if (addr == A_DIVSEL) begin
            for (int c = 0; c < NCH; c++) rdata[sel_lsb(c) +: SEL_W] = sel_o[c];
        end
        if (addr == A_CONTROL) begin
            for (int c = 0; c < NCH; c++) rdata[ctl_lsb(c) +: CTL_W] = ctl_q[c];
        end
        for (int c = 0; c < NCH; c++) begin
            if (addr == period_addr(c)) rdata[CNT_W-1:0] = per_o[c];
            if (addr == compare_addr(c)) rdata[CNT_W-1:0] = cmp_o[c];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ctl
        assign en_o[g]   = ctl_q[g].en;
        assign inv_o[g]  = ctl_q[g].inv;
        assign cont_o[g] = ctl_q[g].cont;
    end
endmodule

// File: rtl/pwm_quad_presc.sv
module pwm_quad_presc
    import pwm_quad_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;

    // ">=" so a lowered limit recovers at once
    assign tick = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
    import pwm_quad_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pre_tick,
    input  logic             en,
    input  logic             inv,
    input  logic             cont,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] compare,
    output logic             run,
    output logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] act_per_q,
    output logic [CNT_W-1:0] act_cmp_q,
    output logic             pwm_o
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last;
    logic             reload;
    logic             raw;

    assign run    = en & cont;
    assign last   = div_last(sel);
    assign tick   = pre_tick && (div_q >= last);
    assign reload = tick && (cnt_q == '0);
    assign raw    = (act_per_q != '0) && (cnt_q <= act_cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= '0;
            cnt_q     <= '0;
            act_per_q <= '0;
            act_cmp_q <= '0;
            pwm_o     <= 1'b0;
        end else begin
            if (pre_tick) div_q <= (div_q >= last) ? '0 : div_q + 1'b1;
            if (!run) begin
                cnt_q     <= period;
                act_per_q <= period;
                act_cmp_q <= compare;
                pwm_o     <= 1'b0;
            end else begin
                if (reload) begin
                    cnt_q     <= period;
                    act_per_q <= period;
                    act_cmp_q <= compare;
                end else if (tick) begin
                    cnt_q <= cnt_q - 1'b1;
                end
                pwm_o <= raw ^ inv;
            end
        end
    end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_quad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic [NPAIR-1:0][PRE_W-1:0] pre_v;
    logic [NPAIR-1:0]            pre_tick_v;
    logic [NCH-1:0][SEL_W-1:0]   sel_v;
    logic [NCH-1:0]              en_v;
    logic [NCH-1:0]              inv_v;
    logic [NCH-1:0]              cont_v;
    logic [NCH-1:0][CNT_W-1:0]   per_v;
    logic [NCH-1:0][CNT_W-1:0]   cmp_v;
    logic [NCH-1:0]              run_v;
    logic [NCH-1:0]              tick_v;
    logic [NCH-1:0][CNT_W-1:0]   cnt_v;
    logic [NCH-1:0][CNT_W-1:0]   act_per_v;
    logic [NCH-1:0][CNT_W-1:0]   act_cmp_v;

    pwm_quad_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .pre_o  (pre_v),
        .sel_o  (sel_v),
        .en_o   (en_v),
        .inv_o  (inv_v),
        .cont_o (cont_v),
        .per_o  (per_v),
        .cmp_o  (cmp_v)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pwm_quad_presc u_presc (
            .clk   (clk),
            .rst   (rst),
            .limit (pre_v[p]),
            .tick  (pre_tick_v[p])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_quad_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .pre_tick  (pre_tick_v[c / 2]),
            .en        (en_v[c]),
            .inv       (inv_v[c]),
            .cont      (cont_v[c]),
            .sel       (sel_v[c]),
            .period    (per_v[c]),
            .compare   (cmp_v[c]),
            .run       (run_v[c]),
            .tick      (tick_v[c]),
            .cnt_q     (cnt_v[c]),
            .act_per_q (act_per_v[c]),
            .act_cmp_q (act_cmp_v[c]),
            .pwm_o     (pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
    import pwm_quad_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic [NCH-1:0]            run_v,
    input logic [NCH-1:0]            inv_v,
    input logic [NCH-1:0]            tick_v,
    input logic [NCH-1:0]            pwm_out,
    input logic [NCH-1:0][CNT_W-1:0] cnt_v,
    input logic [NCH-1:0][CNT_W-1:0] per_v,
    input logic [NCH-1:0][CNT_W-1:0] cmp_v
);
    p_reset_idle_r8: assert property (@(posedge clk)
        rst |=> (pwm_out == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_a
        p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
            !run_v[i] |=> !pwm_out[i]);

        p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
            run_v[i] |-> (cnt_v[i] <= per_v[i]));

        p_hold_shadow_r9: assert property (@(posedge clk) disable iff (rst)
            (run_v[i] && !(tick_v[i] && cnt_v[i] == '0))
            |=> ($stable(per_v[i]) && $stable(cmp_v[i])));

        p_zero_period_r6: assert property (@(posedge clk) disable iff (rst)
            (run_v[i] && per_v[i] == '0) |=> (pwm_out[i] == $past(inv_v[i])));

        p_full_high_r5: assert property (@(posedge clk) disable iff (rst)
            (run_v[i] && per_v[i] != '0 && cmp_v[i] >= per_v[i])
            |=> (pwm_out[i] != $past(inv_v[i])));
    end
endmodule

bind pwm_quad pwm_quad_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run_v   (run_v),
    .inv_v   (inv_v),
    .tick_v  (tick_v),
    .pwm_out (pwm_out),
    .cnt_v   (cnt_v),
    .per_v   (act_per_v),
    .cmp_v   (act_cmp_v)
);

// File: tb/pwm_quad_bench.sv
module pwm_quad_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] sh_pre [2];
    logic [2:0] sh_sel [4];
    logic [3:0] sh_ctl [4];

    always #10 clk = ~clk;

    pwm_quad u_pwm_quad (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic int ctl_pos(input int ch);
        case (ch)
            0: return 0;
            1: return 8;
            2: return 12;
            default: return 16;
        endcase
    endfunction

    function automatic logic [31:0] pre_word();
        return {16'h0, sh_pre[1], sh_pre[0]};
    endfunction

    function automatic logic [31:0] sel_word();
        logic [31:0] w = '0;
        for (int c = 0; c < 4; c++) w[4*c +: 3] = sh_sel[c];
        return w;
    endfunction

    function automatic logic [31:0] ctl_word();
        logic [31:0] w = '0;
        for (int c = 0; c < 4; c++) w[ctl_pos(c) +: 4] = sh_ctl[c];
        return w;
    endfunction

    function automatic int div_of(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 16;
            default: return 1;
        endcase
    endfunction

    function automatic int cycle_len(input int pre, input int code, input int n);
        return (pre + 1) * div_of(code) * (n + 1);
    endfunction

    function automatic int exp_high(input int pre, input int code, input int n,
                                    input int c, input bit inv);
        int t, tot, h;
        t   = (pre + 1) * div_of(code);
        tot = t * (n + 1);
        if (n == 0)      h = 0;
        else if (c >= n) h = tot;
        else             h = (c + 1) * t;
        return inv ? tot - h : h;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cfg_chan(input int ch, input int pre, input int code,
                            input int n, input int c, input bit inv);
        sh_ctl[ch] = 4'b0000;
        bus_wr(6'h08, ctl_word());
        sh_pre[ch / 2] = 8'(pre);
        bus_wr(6'h00, pre_word());
        sh_sel[ch] = 3'(code);
        bus_wr(6'h04, sel_word());
        bus_wr(6'(12 + 8 * ch), 32'(n));
        bus_wr(6'(16 + 8 * ch), 32'(c));
        sh_ctl[ch] = {1'b1, inv, 1'b0, 1'b1};
        bus_wr(6'h08, ctl_word());
    endtask

    task automatic count_high(input int ch, input int len, output int hi);
        hi = 0;
        repeat (len) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        @(negedge clk);
        prev = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic wait_fall(input int ch);
        logic prev;
        @(negedge clk);
        prev = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (prev && !pwm_out[ch]) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic rise_gap(input int ch, output int gap);
        logic prev;
        wait_rise(ch);
        gap  = 0;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            gap++;
            if (!prev && pwm_out[ch]) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic high_len(input int ch, output int len);
        wait_rise(ch);
        len = 1;
        forever begin
            @(negedge clk);
            if (pwm_out[ch]) len++;
            else break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int v, seed_val;
        int ch, pre, code, n, c;
        bit inv;

        seed_val = int'($urandom(32'd1357));
        for (int i = 0; i < 2; i++) sh_pre[i] = '0;
        for (int i = 0; i < 4; i++) begin
            sh_sel[i] = '0;
            sh_ctl[i] = '0;
        end

        // R8: reset state
        repeat (4) @(negedge clk);
        check("R8", "outputs in reset", int'(pwm_out), 0);
        rst = 1'b0;
        for (int a = 0; a <= 40; a += 4) begin
            bus_rd(6'(a), rd);
            check("R8", $sformatf("reg 0x%0h after reset", a), int'(rd), 0);
        end
        check("R8", "outputs after reset", int'(pwm_out), 0);

        // R1: read-back with reserved bits masked
        bus_wr(6'h00, 32'hFFFF_ABCD);
        bus_rd(6'h00, rd);
        check("R1", "prescale readback", int'(rd), 32'h0000_ABCD);
        bus_wr(6'h04, 32'hFFFF_FFFF);
        bus_rd(6'h04, rd);
        check("R1", "divsel readback", int'(rd), 32'h0000_7777);
        bus_wr(6'h08, 32'hFFFF_FFFF);
        bus_rd(6'h08, rd);
        check("R1", "control readback", int'(rd), 32'h000F_FF0F);
        bus_wr(6'h1C, 32'hDEAD_BEEF);
        bus_rd(6'h1C, rd);
        check("R1", "period ch2 readback", int'(rd), 32'h0000_BEEF);
        bus_wr(6'h28, 32'h1234_5678);
        bus_rd(6'h28, rd);
        check("R1", "compare ch3 readback", int'(rd), 32'h0000_5678);
        bus_rd(6'h3C, rd);
        check("R1", "unmapped offset", int'(rd), 0);
        bus_wr(6'h08, 32'h0);
        bus_wr(6'h00, 32'h0);
        bus_wr(6'h04, 32'h0);
        bus_wr(6'h1C, 32'h0);
        bus_wr(6'h28, 32'h0);

        // R7: enable without continuous, continuous without enable
        cfg_chan(0, 0, 4, 9, 3, 1'b0);
        sh_ctl[0] = 4'b0001;
        bus_wr(6'h08, ctl_word());
        count_high(0, 60, v);
        check("R7", "enable only", v, 0);
        sh_ctl[0] = 4'b0101;
        bus_wr(6'h08, ctl_word());
        count_high(0, 60, v);
        check("R7", "enable+invert without continuous", v, 0);
        sh_ctl[0] = 4'b1100;
        bus_wr(6'h08, ctl_word());
        count_high(0, 60, v);
        check("R7", "continuous without enable", v, 0);

        // R3: divider codes
        cfg_chan(0, 0, 4, 9, 3, 1'b0);
        repeat (40) @(negedge clk);
        rise_gap(0, v);
        check("R3", "code 4 divide by 1 period", v, 10);
        count_high(0, 10, v);
        check("R5", "code 4 high time", v, 4);
        cfg_chan(0, 0, 0, 9, 3, 1'b0);
        repeat (60) @(negedge clk);
        rise_gap(0, v);
        check("R3", "code 0 divide by 2 period", v, 20);
        cfg_chan(0, 0, 3, 9, 3, 1'b0);
        repeat (360) @(negedge clk);
        rise_gap(0, v);
        check("R3", "code 3 divide by 16 period", v, 160);

        // R6: period zero
        cfg_chan(1, 0, 4, 0, 5, 1'b0);
        repeat (20) @(negedge clk);
        count_high(1, 40, v);
        check("R6", "period 0 low", v, 0);
        cfg_chan(1, 0, 4, 0, 5, 1'b1);
        repeat (20) @(negedge clk);
        count_high(1, 40, v);
        check("R6", "period 0 inverted high", v, 40);

        // R5: compare above period
        cfg_chan(1, 0, 0, 6, 16'hFFFF, 1'b0);
        repeat (40) @(negedge clk);
        count_high(1, 14, v);
        check("R5", "compare above period full high", v, 14);

        // R2: prescaler pairing
        cfg_chan(1, 2, 4, 4, 1, 1'b0);
        cfg_chan(2, 0, 4, 4, 1, 1'b0);
        repeat (60) @(negedge clk);
        rise_gap(1, v);
        check("R2", "ch1 uses low prescaler", v, 15);
        rise_gap(2, v);
        check("R2", "ch2 uses high prescaler", v, 5);

        // R10: inversion
        cfg_chan(3, 1, 0, 7, 2, 1'b1);
        repeat (100) @(negedge clk);
        count_high(3, 32, v);
        check("R10", "inverted high time", v, 20);

        // R9: compare change applies at the next boundary
        cfg_chan(0, 0, 4, 20, 5, 1'b0);
        repeat (60) @(negedge clk);
        wait_fall(0);
        bus_wr(6'h10, 32'd12);
        high_len(0, v);
        check("R9", "pulse after mid-cycle write keeps old compare", v, 6);
        high_len(0, v);
        check("R9", "following pulse uses new compare", v, 13);

        // R4/R5/R10 random configurations
        for (int it = 0; it < 12; it++) begin
            ch   = int'($urandom % 4);
            pre  = int'($urandom % 3);
            code = int'($urandom % 5);
            n    = int'($urandom % 21);
            c    = int'($urandom % 24);
            inv  = 1'($urandom % 2);
            cfg_chan(ch, pre, code, n, c, inv);
            repeat (2 * cycle_len(pre, code, n) + 40) @(negedge clk);
            count_high(ch, cycle_len(pre, code, n), v);
            check(inv ? "R10" : "R5",
                  $sformatf("random ch%0d p%0d code%0d N%0d C%0d high time", ch, pre, code, n, c),
                  v, exp_high(pre, code, n, c, inv));
            if (n > 0 && c < n) begin
                rise_gap(ch, v);
                check("R4", $sformatf("random ch%0d cycle length", ch), v,
                      cycle_len(pre, code, n));
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule